// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts cycles and selected hardware events for profiling. It has one dedicated cycle counter and a parameterised set of event counters, four by default. Each event counter watches one line of a wide event bus, 128 lines by default, and the line is chosen by a per-counter event selector. Software reaches the unit through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the address.

To sample, software loads a counter with the two's-complement negative of the sampling period and enables it. When the counter wraps, the unit latches an overflow flag. A level interrupt stays raised while any flagged counter has its interrupt enabled. Event counters are reached indirectly through a select register. The cycle counter has its own register and an optional divide-by-64 prescaler. The trace-export and debug-halt control bits are kept as plain storage.

Top module: `pmu_top`

Register word addresses on `addr_i`: 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 overflow flags, 5 counter select, 6 indirect event selector, 7 indirect event count, 8 cycle count. Other addresses read 0 and ignore writes. The enable, interrupt-enable and flag registers share one layout: bit 31 is the cycle counter and bit k (k < 4) is event counter k. All other bits read 0.

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Control bits: bit 0 is the global run bit, bit 3 is cycle divide-by-64, and bits 4 and 5 are plain storage. These four bits read back as written. Bits 1 and 2 are action bits that read 0. Bits 31:6 read 0.
- R3: A 1 written to enable-set turns the matching counter on, and a 1 written to enable-clear turns it off. Zero bits have no effect. Both addresses read the enable state as 0x8000000F-masked bits.
- R4: Event counter k increments by one at each clock edge where the run bit, its own enable and its selected event line are all high. Other event lines, a disabled counter and a cleared run bit leave it unchanged.
- R5: With the run bit and its enable set, the cycle counter increments every clock. With control bit 3 set, it increments on every 64th enabled clock instead. The 6-bit prescaler advances only on enabled clocks and holds otherwise.
- R6: The select register keeps 5 bits. Event-selector writes keep 7 bits. The indirect selector and count registers access event counter k when select equals k. With select at 4 or above, they read 0 and ignore writes. The cycle counter is read and written at its own address.
- R7: An increment from all ones to 0 sets that counter's overflow flag. Writing 1 to a flag bit clears it, and writing 0 leaves it. A wrap in the same cycle as a clearing write leaves the flag set.
- R8: `irq_o` is high exactly while some flag is set whose interrupt enable is set. Interrupt enables are set by writing 1 and are cleared only by reset.
- R9: Writing control bit 1 zeroes every event counter and leaves the cycle counter alone. Writing control bit 2 zeroes the cycle counter and its prescaler.
- R10: A register write to a counter in the same cycle as an increment of that counter wins, and the counter holds the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| event_i | input | N_EVENTS (128) | Event lines, sampled each clock |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The bench drives a counter from 0xFFFFFFFE through two events. A design that flags one step early, or never flags, fails on the flag and interrupt reads. It then lands a wrap and a flag-clearing write on the same edge. A design that lets the clear win loses the sample. The prescaler is taken to 63 enabled clocks, then paused, then given one more clock. This catches a divider that is off by one or that runs while the counter is disabled. Writes are also placed on the same edge as counting, which exposes any increment that overrides a load. Select values of 31 and event line 127 exercise the edges of the indirect path.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int CYC_BIT = 31;
  localparam int SEL_W   = 5;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_EVRST = 1;
  localparam int CTRL_CYRST = 2;
  localparam int CTRL_DIV   = 3;
  localparam int CTRL_W     = 6;
  localparam logic [CTRL_W-1:0] CTRL_STORE_MASK = 6'b111001;

  typedef enum logic [3:0] {
    REG_CTRL    = 4'd0,
    REG_EN_SET  = 4'd1,
    REG_EN_CLR  = 4'd2,
    REG_IRQ_SET = 4'd3,
    REG_FLAG    = 4'd4,
    REG_SEL     = 4'd5,
    REG_EVSEL   = 4'd6,
    REG_EVCNT   = 4'd7,
    REG_CYC     = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/pmu_cnt.sv
module pmu_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // clear and load beat increment
  assign wrap_o = inc_i && !load_i && !clr_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end

  a_r10_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> cnt_o == $past(load_val_i));
  a_r7_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0);
  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && !clr_i |=> cnt_o == $past(cnt_o) + W'(1));
endmodule

// File: rtl/pmu_presc.sv
module pmu_presc #(
  parameter int W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = adv_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + W'(1);
  end

  a_r5_presc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !clr_i |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int N_EVT_CNT = 4,
  parameter int N_EVENTS  = 128,
  parameter int CNT_W     = 32,
  parameter int PRESC_W   = 6,
  parameter int ADDR_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [N_EVENTS-1:0] event_i,
  output logic                irq_o
);
  localparam int NC      = N_EVT_CNT + 1;
  localparam int CYC     = N_EVT_CNT;
  localparam int EVSEL_W = $clog2(N_EVENTS);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [NC-1:0]      en_q, irq_en_q, flag_q, wrap;
  logic [SEL_W-1:0]   sel_q;
  logic [EVSEL_W-1:0] evsel_q [N_EVT_CNT];
  logic [CNT_W-1:0]   cnt [NC];
  logic [NC-1:0]      wvec;
  logic               sel_ok, ev_clr, cy_clr, run_cyc, presc_tc;
  logic               wr_ctrl, wr_ens, wr_enc, wr_irq, wr_flag, wr_sel, wr_evsel, wr_evcnt, wr_cyc;

  function automatic logic [DATA_W-1:0] to_reg(input logic [NC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[N_EVT_CNT-1:0] = v[N_EVT_CNT-1:0];
    r[CYC_BIT] = v[CYC];
    return r;
  endfunction

  assign wvec     = {wdata_i[CYC_BIT], wdata_i[N_EVT_CNT-1:0]};
  assign wr_ctrl  = wr_en_i && addr_i == ADDR_W'(REG_CTRL);
  assign wr_ens   = wr_en_i && addr_i == ADDR_W'(REG_EN_SET);
  assign wr_enc   = wr_en_i && addr_i == ADDR_W'(REG_EN_CLR);
  assign wr_irq   = wr_en_i && addr_i == ADDR_W'(REG_IRQ_SET);
  assign wr_flag  = wr_en_i && addr_i == ADDR_W'(REG_FLAG);
  assign wr_sel   = wr_en_i && addr_i == ADDR_W'(REG_SEL);
  assign wr_evsel = wr_en_i && addr_i == ADDR_W'(REG_EVSEL);
  assign wr_evcnt = wr_en_i && addr_i == ADDR_W'(REG_EVCNT);
  assign wr_cyc   = wr_en_i && addr_i == ADDR_W'(REG_CYC);

  assign sel_ok  = int'(sel_q) < N_EVT_CNT;
  assign ev_clr  = wr_ctrl && wdata_i[CTRL_EVRST];
  assign cy_clr  = wr_ctrl && wdata_i[CTRL_CYRST];
  assign run_cyc = ctrl_q[CTRL_RUN] && en_q[CYC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      en_q     <= '0;
      irq_en_q <= '0;
      flag_q   <= '0;
      sel_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0] & CTRL_STORE_MASK;
      if (wr_ens)      en_q <= en_q | wvec;
      else if (wr_enc) en_q <= en_q & ~wvec;
      if (wr_irq) irq_en_q <= irq_en_q | wvec;
      // a wrap on the clearing edge keeps its flag
      flag_q <= (flag_q & ~(wr_flag ? wvec : '0)) | wrap;
      if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < N_EVT_CNT; i++) begin : g_evt
    logic hit;
    assign hit = sel_ok && sel_q == SEL_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                evsel_q[i] <= '0;
      else if (wr_evsel && hit)   evsel_q[i] <= wdata_i[EVSEL_W-1:0];
    end

    pmu_cnt #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (ev_clr),
      .load_i     (wr_evcnt && hit),
      .load_val_i (wdata_i[CNT_W-1:0]),
      .inc_i      (ctrl_q[CTRL_RUN] && en_q[i] && event_i[evsel_q[i]]),
      .cnt_o      (cnt[i]),
      .wrap_o     (wrap[i])
    );
  end

  pmu_presc #(.W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cy_clr),
    .adv_i  (run_cyc),
    .tc_o   (presc_tc)
  );

  pmu_cnt #(.W(CNT_W)) u_cyc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cy_clr),
    .load_i     (wr_cyc),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .inc_i      (run_cyc && (!ctrl_q[CTRL_DIV] || presc_tc)),
    .cnt_o      (cnt[CYC]),
    .wrap_o     (wrap[CYC])
  );

  assign irq_o = |(flag_q & irq_en_q);

  always_comb begin
    logic [EVSEL_W-1:0] evs;
    logic [CNT_W-1:0]   evc;
    evs = '0;
    evc = '0;
    for (int i = 0; i < N_EVT_CNT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        evs = evsel_q[i];
        evc = cnt[i];
      end
    end
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(REG_CTRL):    rdata_o = DATA_W'(ctrl_q);
      ADDR_W'(REG_EN_SET),
      ADDR_W'(REG_EN_CLR):  rdata_o = to_reg(en_q);
      ADDR_W'(REG_IRQ_SET): rdata_o = to_reg(irq_en_q);
      ADDR_W'(REG_FLAG):    rdata_o = to_reg(flag_q);
      ADDR_W'(REG_SEL):     rdata_o = DATA_W'(sel_q);
      ADDR_W'(REG_EVSEL):   rdata_o = DATA_W'(evs);
      ADDR_W'(REG_EVCNT):   rdata_o = DATA_W'(evc);
      ADDR_W'(REG_CYC):     rdata_o = DATA_W'(cnt[CYC]);
      default:              rdata_o = '0;
    endcase
  end

  a_r3_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ens && !wr_enc |=> $stable(en_q));
  a_r8_irq_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_en_q & $past(irq_en_q)) == $past(irq_en_q));
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flag |=> (flag_q & $past(flag_q)) == $past(flag_q));
  a_r6_sel_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ok |-> rdata_o == '0 || addr_i != ADDR_W'(REG_EVCNT));
endmodule

// File: tb/pmu_top_tb.sv
module pmu_top_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [3:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [127:0] event_i = '0;
  logic         irq_o;
  int total = 0;
  int bad = 0;

  localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_IRQ = 4'd3,
                         A_FLG = 4'd4, A_SEL = 4'd5, A_EVS = 4'd6, A_EVC = 4'd7, A_CYC = 4'd8;

  // {write addr, write data, read addr, expected, requirement}
  localparam logic [79:0] VEC [15] = '{
    {4'd0, 32'hFFFF_FFF8, 4'd0, 32'h0000_0038, 8'd2},   // R2 stored bits
    {4'd0, 32'h0000_0006, 4'd0, 32'h0000_0000, 8'd2},   // R2 action bits read 0
    {4'd1, 32'hFFFF_FFFF, 4'd1, 32'h8000_000F, 8'd3},   // R3 mask
    {4'd2, 32'h0000_0005, 4'd2, 32'h8000_000A, 8'd3},
    {4'd1, 32'h0000_0000, 4'd1, 32'h8000_000A, 8'd3},   // R3 zero no effect
    {4'd2, 32'h8000_0000, 4'd1, 32'h0000_000A, 8'd3},
    {4'd2, 32'h0000_000F, 4'd2, 32'h0000_0000, 8'd3},
    {4'd5, 32'hFFFF_FFFF, 4'd5, 32'h0000_001F, 8'd6},   // R6 select width
    {4'd6, 32'h0000_00FF, 4'd6, 32'h0000_0000, 8'd6},   // R6 out-of-range select
    {4'd5, 32'h0000_0002, 4'd5, 32'h0000_0002, 8'd6},
    {4'd6, 32'hFFFF_FFFF, 4'd6, 32'h0000_007F, 8'd6},
    {4'd7, 32'h1234_5678, 4'd7, 32'h1234_5678, 8'd6},
    {4'd5, 32'h0000_0001, 4'd7, 32'h0000_0000, 8'd6},
    {4'd5, 32'h0000_0002, 4'd6, 32'h0000_007F, 8'd6},
    {4'd8, 32'hDEAD_BEEF, 4'd8, 32'hDEAD_BEEF, 8'd6}
  };

  pmu_top u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .event_i (event_i),
    .irq_o   (irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(input int line);
    event_i[line] = 1'b1;
    @(negedge clk_i);
    event_i[line] = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][79:76], VEC[i][75:44]);
      rd(VEC[i][43:40], v);
      chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), v, VEC[i][39:8]);
    end

    // R4 event counting
    wr(A_SEL, 0); wr(A_EVS, 5);
    wr(A_SEL, 1); wr(A_EVS, 5);
    wr(A_SEL, 3); wr(A_EVS, 127);
    wr(A_SEL, 0); wr(A_EVC, 0);
    wr(A_ENS, 32'h1); wr(A_CTRL, 32'h1);
    event_i[5] = 1'b1; event_i[6] = 1'b1;
    repeat (7) @(negedge clk_i);
    event_i = '0;
    rd(A_EVC, v); chk("R4 counter0 seven events", v, 32'd7);
    wr(A_SEL, 1);
    rd(A_EVC, v); chk("R4 disabled counter1 idle", v, 32'd0);
    wr(A_SEL, 3); wr(A_EVC, 0); wr(A_ENS, 32'h8);
    event_i[127] = 1'b1;
    repeat (4) @(negedge clk_i);
    event_i = '0;
    rd(A_EVC, v); chk("R4 counter3 line 127", v, 32'd4);
    wr(A_CTRL, 0);
    event_i[5] = 1'b1;
    repeat (3) @(negedge clk_i);
    event_i = '0;
    wr(A_SEL, 0);
    rd(A_EVC, v); chk("R4 run bit clear holds", v, 32'd7);

    // R5 cycle counter, direct and divided
    wr(A_ENS, 32'h8000_0000); wr(A_CYC, 0);
    wr(A_CTRL, 32'h1);
    repeat (9) @(negedge clk_i);
    wr(A_CTRL, 0);
    rd(A_CYC, v); chk("R5 cycle count ten", v, 32'd10);
    wr(A_CTRL, 32'hD);
    repeat (62) @(negedge clk_i);
    wr(A_CTRL, 32'h8);
    rd(A_CYC, v); chk("R5 divide 63 clocks", v, 32'd0);
    wr(A_CTRL, 32'h9);
    wr(A_CTRL, 32'h8);
    rd(A_CYC, v); chk("R5 divide 64th clock", v, 32'd1);
    wr(A_CTRL, 32'h4);
    rd(A_CYC, v); chk("R9 cycle reset", v, 32'd0);

    // R7 R8 overflow and interrupt
    wr(A_ENC, 32'hFFFF_FFFF);
    wr(A_SEL, 0); wr(A_EVC, 32'hFFFF_FFFE);
    wr(A_ENS, 32'h1); wr(A_IRQ, 32'h1); wr(A_CTRL, 32'h1);
    pulse(5);
    rd(A_FLG, v); chk("R7 no flag at all ones", v, 32'h0);
    chk("R8 irq low before wrap", {31'b0, irq_o}, 32'h0);
    pulse(5);
    rd(A_FLG, v); chk("R7 flag on wrap", v, 32'h1);
    rd(A_EVC, v); chk("R7 wrapped to zero", v, 32'h0);
    chk("R8 irq high", {31'b0, irq_o}, 32'h1);
    wr(A_FLG, 0);
    rd(A_FLG, v); chk("R7 zero write keeps flag", v, 32'h1);
    wr(A_FLG, 32'h1);
    rd(A_FLG, v); chk("R7 flag cleared", v, 32'h0);
    chk("R8 irq dropped", {31'b0, irq_o}, 32'h0);
    wr(A_SEL, 1); wr(A_EVS, 6); wr(A_EVC, 32'hFFFF_FFFF); wr(A_ENS, 32'h2);
    pulse(6);
    rd(A_FLG, v); chk("R7 counter1 flag", v, 32'h2);
    chk("R8 masked flag no irq", {31'b0, irq_o}, 32'h0);
    wr(A_IRQ, 32'h2);
    chk("R8 late enable raises irq", {31'b0, irq_o}, 32'h1);
    wr(A_FLG, 32'h2);
    wr(A_SEL, 0); wr(A_EVC, 32'hFFFF_FFFF);
    addr_i = A_FLG; wdata_i = 32'h1; wr_en_i = 1'b1; event_i[5] = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; event_i = '0;
    rd(A_FLG, v); chk("R7 wrap beats clear", v, 32'h1);
    chk("R8 irq on same-edge wrap", {31'b0, irq_o}, 32'h1);
    wr(A_FLG, 32'h1);

    // R10 write beats increment
    event_i[5] = 1'b1;
    repeat (3) @(negedge clk_i);
    wr(A_EVC, 32'd100);
    event_i = '0;
    rd(A_EVC, v); chk("R10 event write wins", v, 32'd100);
    wr(A_ENS, 32'h8000_0000);
    wr(A_CYC, 32'd500);
    wr(A_CTRL, 0);
    rd(A_CYC, v); chk("R10 cycle write wins", v, 32'd501);

    // R9 event counter reset leaves cycle counter
    wr(A_CYC, 32'd55);
    wr(A_CTRL, 32'h2);
    rd(A_EVC, v); chk("R9 counter0 zeroed", v, 32'h0);
    wr(A_SEL, 2);
    rd(A_EVC, v); chk("R9 counter2 zeroed", v, 32'h0);
    rd(A_CYC, v); chk("R9 cycle untouched", v, 32'd55);
    rd(A_CTRL, v); chk("R2 reset bit reads zero", v, 32'h0);

    finish_run();
  end
endmodule